// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast source clock down to a slower output clock. Two separate 8-bit counts set how long the output stays high and how long it stays low. The division ratio is the sum of the two counts, so one pair of settings fixes both the frequency and the duty cycle. A pass-through control sends the source clock straight to the output. A half-cycle control moves the high-to-low transition onto a falling edge of the source clock. With that control set, an odd ratio can still give an even 50/50 split.

Software writes a new setting through a parallel port with a one-cycle load strobe. The value waits in a shadow register. It is copied into the working register only when the current low phase ends. Each output period therefore runs entirely on one setting, and no partial period ever reaches the output.

Top module: `pdiv_clk_divider`

## Requirements
- R1: With the half-cycle and pass-through controls clear, the output stays high for exactly `cfg_high` source cycles and then low for exactly `cfg_low` source cycles. Every output edge follows a rising source edge.
- R2: A count field of 0 means 256 cycles.
- R3: With `cfg_bypass` = 1 active, the output equals the source clock, so each high run and each low run lasts one half-cycle.
- R4: With `cfg_odd` = 1 active, the high run lasts 2·high−1 source half-cycles and the low run lasts 2·low+1 half-cycles. The falling output edge follows a falling source edge. For example, high 2 and low 1 gives 3 half-cycles high and 3 half-cycles low.
- R5: A value captured on `cfg_load` takes effect only at the start of the next output period. The period in progress completes with its old high and low widths.
- R6: While `rst` is high, the output is low. The first rising source edge after `rst` falls starts a high phase. The reset settings are high 1, low 1, with both controls clear.
- R7: If several loads arrive within one period, the last one is applied at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that captures the settings below |
| cfg_high | input | 8 | High-phase length in source cycles (0 = 256) |
| cfg_low | input | 8 | Low-phase length in source cycles (0 = 256) |
| cfg_bypass | input | 1 | 1: output follows the source clock |
| cfg_odd | input | 1 | 1: falling output edge moves half a cycle earlier |
| clk_out | output | 1 | Divided clock |

## Verification
The case hardest to reach is a load that lands in the middle of a period. The bench shows that the old widths survive to the end of that period, and that a second load in the same period replaces the first. To do this, the bench locks onto a rising output edge and fires the strobe partway through that high phase. It then measures three consecutive runs at half-cycle resolution. The bench also sweeps every high/low pair from 1 to 6 in both odd modes, plus the 256-cycle case and pass-through. Each run length is compared with an expected half-cycle count computed from the settings.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int CNT_W = 8;
  localparam int LEN_W = CNT_W + 1;

  typedef struct packed {
    logic             bypass;
    logic             odd;
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
  } pdiv_cfg_t;

  function automatic logic [LEN_W-1:0] pdiv_len(input logic [CNT_W-1:0] v);
    return (v == '0) ? LEN_W'(1) << CNT_W : LEN_W'(v);
  endfunction
endpackage

// File: rtl/pdiv_cfg_shadow.sv
module pdiv_cfg_shadow
  import pdiv_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_HIGH = 1,
  parameter logic [CNT_W-1:0] RST_LOW  = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  pdiv_cfg_t cfg_in,
  input  logic      boundary,
  output pdiv_cfg_t active
);
  localparam pdiv_cfg_t RST_CFG = '{bypass: 1'b0, odd: 1'b0, high: RST_HIGH, low: RST_LOW};

  pdiv_cfg_t shadow;
  logic      pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= RST_CFG;
      pending <= 1'b0;
      active  <= RST_CFG;
    end else begin
      if (load) begin
        shadow  <= cfg_in;
        pending <= 1'b1;
      end else if (boundary && pending) begin
        pending <= 1'b0;
      end
      if (boundary && pending) active <= shadow;
    end
  end

  AST_ACTIVE_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !$past(boundary) |-> $stable(active)); // R5
endmodule

// File: rtl/pdiv_phase_ctr.sv
module pdiv_phase_ctr
  import pdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] low_len,
  output logic             q_rise,
  output logic             last_high,
  output logic             boundary
);
  logic             fresh;
  logic             in_high;
  logic [CNT_W-1:0] cnt;
  logic             high_done;
  logic             low_done;

  always_comb begin
    high_done = (LEN_W'(cnt) == high_len - LEN_W'(1));
    low_done  = (LEN_W'(cnt) == low_len - LEN_W'(1));
    last_high = in_high && high_done;
    boundary  = !rst && (fresh || (!in_high && low_done));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh   <= 1'b1;
      in_high <= 1'b0;
      cnt     <= '0;
      q_rise  <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (boundary) begin
        in_high <= 1'b1;
        q_rise  <= 1'b1;
        cnt     <= '0;
      end else if (in_high && high_done) begin
        in_high <= 1'b0;
        q_rise  <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    LEN_W'(cnt) < (in_high ? high_len : low_len)); // R1
  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($rose(q_rise) && high_len != LEN_W'(1)) |=> q_rise); // R1
endmodule

// File: rtl/pdiv_half_shift.sv
module pdiv_half_shift (
  input  logic clk,
  input  logic rst,
  input  logic q_rise,
  input  logic last_high,
  input  logic odd,
  output logic q_out
);
  logic kill_fall;

  always_ff @(negedge clk) begin
    if (rst) kill_fall <= 1'b0;
    else     kill_fall <= last_high && odd;
  end

  assign q_out = q_rise && !kill_fall;

  AST_KILL_ONLY_ODD: assert property (@(negedge clk) disable iff (rst)
    kill_fall |-> odd); // R4
endmodule

// File: rtl/pdiv_clk_divider.sv
module pdiv_clk_divider
  import pdiv_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_HIGH = 1,
  parameter logic [CNT_W-1:0] RST_LOW  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_bypass,
  input  logic             cfg_odd,
  output logic             clk_out
);
  pdiv_cfg_t        cfg_in;
  pdiv_cfg_t        active;
  logic             boundary;
  logic             q_rise;
  logic             last_high;
  logic             q_div;
  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] low_len;

  assign cfg_in   = '{bypass: cfg_bypass, odd: cfg_odd, high: cfg_high, low: cfg_low};
  assign high_len = pdiv_len(active.high);
  assign low_len  = pdiv_len(active.low);

  pdiv_cfg_shadow #(.RST_HIGH(RST_HIGH), .RST_LOW(RST_LOW)) u_shadow (
    .clk(clk), .rst(rst), .load(cfg_load), .cfg_in(cfg_in),
    .boundary(boundary), .active(active)
  );

  pdiv_phase_ctr u_ctr (
    .clk(clk), .rst(rst), .high_len(high_len), .low_len(low_len),
    .q_rise(q_rise), .last_high(last_high), .boundary(boundary)
  );

  pdiv_half_shift u_shift (
    .clk(clk), .rst(rst), .q_rise(q_rise), .last_high(last_high),
    .odd(active.odd), .q_out(q_div)
  );

  assign clk_out = active.bypass ? clk : q_div;

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) && rst |-> !q_div); // R6
endmodule

// File: tb/pdiv_clk_divider_bench.sv
`timescale 1ns/1ps
module pdiv_clk_divider_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [7:0] cfg_high = 8'd1;
  logic [7:0] cfg_low = 8'd1;
  logic       cfg_bypass = 1'b0;
  logic       cfg_odd = 1'b0;
  logic       clk_out;
  logic       s;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  pdiv_clk_divider u_pdiv_clk_divider (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_high(cfg_high),
    .cfg_low(cfg_low), .cfg_bypass(cfg_bypass), .cfg_odd(cfg_odd),
    .clk_out(clk_out)
  );

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic smp;
    @(clk);
    #1;
    s = clk_out;
  endtask

  task automatic sync_rise;
    logic prev;
    smp();
    prev = s;
    smp();
    while (!(s && !prev)) begin
      prev = s;
      smp();
    end
  endtask

  task automatic count_runs(output int h, output int l);
    h = 1;
    smp();
    while (s) begin h++; smp(); end
    l = 1;
    smp();
    while (!s) begin l++; smp(); end
  endtask

  function automatic int len(input int v);
    return (v == 0) ? 256 : v;
  endfunction

  task automatic apply(input int h, input int l, input logic b, input logic o);
    cfg_high = 8'(h); cfg_low = 8'(l); cfg_bypass = b; cfg_odd = o;
    cfg_load = 1'b1;
    @(posedge clk);
    #1;
    cfg_load = 1'b0;
  endtask

  task automatic measure(input string req, input int h, input int l, input logic b, input logic o);
    int mh, ml;
    apply(h, l, b, o);
    sync_rise();
    count_runs(mh, ml);
    check(req, mh, b ? 1 : 2*len(h) - int'(o));
    check(req, ml, b ? 1 : 2*len(l) + int'(o));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int h1, l1, h2, l2, h3, l3;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      smp();
      check("R6 low in reset", int'(clk_out), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R6 first edge high", int'(clk_out), 1);
    s = 1'b1;
    count_runs(h1, l1);
    check("R6 default high", h1, 2);
    check("R6 default low", l1, 2);

    // R1 even ratios: 5/5 and 4/6
    measure("R1", 5, 5, 1'b0, 1'b0);
    measure("R1", 4, 6, 1'b0, 1'b0);
    measure("R1", 2, 1, 1'b0, 1'b0);
    // R4 odd mode at divide-by-3
    measure("R4", 2, 1, 1'b0, 1'b1);
    // sweep R1 and R4
    for (int o = 0; o < 2; o++)
      for (int h = 1; h <= 6; h++)
        for (int l = 1; l <= 6; l++)
          measure(o ? "R4 sweep" : "R1 sweep", h, l, 1'b0, logic'(o));
    // R2 zero means 256
    measure("R2", 0, 3, 1'b0, 1'b0);
    measure("R2", 2, 0, 1'b0, 1'b1);
    // R3 pass-through
    measure("R3", 3, 3, 1'b1, 1'b0);
    measure("R3", 7, 2, 1'b1, 1'b1);

    // R5 mid-period load keeps the running period
    measure("R5 setup", 4, 4, 1'b0, 1'b0);
    sync_rise();
    fork
      apply(2, 6, 1'b0, 1'b0);
    join_none
    count_runs(h1, l1);
    count_runs(h2, l2);
    check("R5 old high", h1, 8);
    check("R5 old low", l1, 8);
    check("R5 new high", h2, 4);
    check("R5 new low", l2, 12);

    // R7 last of two loads wins
    sync_rise();
    fork
      begin
        apply(5, 1, 1'b0, 1'b0);
        apply(3, 2, 1'b0, 1'b1);
      end
    join_none
    count_runs(h1, l1);
    count_runs(h3, l3);
    check("R7 old high", h1, 4);
    check("R7 old low", l1, 12);
    check("R7 last high", h3, 5);
    check("R7 last low", l3, 5);

    report();
  end
endmodule